// File: doc/BRIEF.md
# Fractional n-of-32 Clock Enable Divider

This block turns a parent clock into a clock-enable pulse train whose average rate is a programmable fraction of the parent rate. The parent clock first passes through an optional fixed integer predivider. This stage produces one "tick" every `FIXED_DIV` parent cycles. A fractional stage then lets through `mult` of every 32 ticks, with `mult` anywhere from 1 to 32. A phase accumulator spreads those pulses as evenly as it can. The resulting enable rate is parent_rate × mult / (32 × FIXED_DIV).

Software programs the ratio through a small register port. A 5-bit ratio code sits at a configurable bit offset inside a 32-bit rate register, so several such dividers can share one register. The code is stored inverted: `mult = 32 − code`, which makes code 0 full rate. Writing the code alone does nothing. The change is committed by setting bit 31 of a separate commit register. That bit stays set as a busy flag until the new ratio has been switched in at the next 32-tick window boundary, and then it clears by itself. Software is expected to poll this flag and not to start a new change while it is set.

Top module: `nof32_gate`

## Requirements
- R1: `clkEn` is high for single parent cycles only. Over every window of 32 ticks it is high exactly `mult` times, where `mult = 32 − code` and `code` is the 5-bit field at bits `FIELD_LSB+4:FIELD_LSB` of the rate register (address `RATE_ADDR`).
- R2: Code 0 gives a pulse on every tick (32 per window). Code 31 gives one pulse per window.
- R3: Within a window of constant ratio, the distance between consecutive pulses is either floor(32/mult) or ceil(32/mult) ticks.
- R4: A tick occurs every `FIXED_DIV` parent cycles, counted from reset release. With `FIXED_DIV = 1` every cycle is a tick. Windows end on parent cycle 32·`FIXED_DIV`·k after reset. At full rate the first pulse appears `FIXED_DIV` cycles after reset.
- R5: Writing the ratio field without a commit has no effect on `clkEn`.
- R6: Writing a 1 to bit 31 of the commit register (address `KICK_ADDR`) sets the busy flag, which reads back on bit 31. Bits 30:0 of the commit register read as 0. Writing 0 to bit 31 does not clear the flag.
- R7: A committed code takes effect from the first tick of the window after the boundary that ends the current window. The code taken is the field value at that boundary, so a rewrite made before the boundary wins. The window in which the commit was written still runs at the old ratio.
- R8: The busy flag clears one parent cycle after the boundary tick that applies the code.
- R9: The rate register stores and reads back all 32 bits. Bits outside the field do not affect `clkEn`.
- R10: After reset, `clkEn` is 0, both registers read 0, the busy flag is clear and the active ratio is full rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| clkEn | output | 1 | Gated clock-enable pulse |

## Verification
The pulse count per window is checked at full rate, at one-of-32, and at an odd ratio (five of 32). Full rate exposes the predivider cadence and the phase of the first pulse. One-of-32 exposes the accumulator wrap at its narrowest. Five of 32 cannot divide the window evenly, so the spacing of its pulses separates an even spread from a bunched one. Further cases cover a field written without a commit, a field rewritten while a commit is pending, and junk bits around the field. These separate commit gating, sampling at the boundary and field extraction. The busy flag is read on both sides of its clearing edge.

// File: rtl/nof32_gate_pkg.sv
package nof32_gate_pkg;

  localparam int WIN_TICKS = 32;
  localparam int CODE_W    = 5;
  localparam int REG_W     = 32;
  localparam int KICK_BIT  = 31;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;    // one predivided step
    logic winEnd;  // tick that closes the 32-tick window
    logic load;    // winEnd with a pending commit
  } gateStrb_t;

endpackage

// File: rtl/nof32_prediv.sv
module nof32_prediv #(
  parameter int FIXED_DIV = 1
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);

  localparam int CNT_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;

  generate
    if (FIXED_DIV == 1) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_count
      logic [CNT_W-1:0] preCnt;
      localparam logic [CNT_W-1:0] LAST = CNT_W'(FIXED_DIV - 1);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (preCnt == LAST) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign tick = (preCnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/nof32_gate_ctrl.sv
module nof32_gate_ctrl
  import nof32_gate_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int RATE_ADDR = 0,
  parameter int KICK_ADDR = 1,
  parameter int FIELD_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              tick,
  output gateStrb_t         strb,
  output logic [CODE_W-1:0] newCode,
  output logic              kickBusy
);

  localparam logic [ADDR_W-1:0] RATE_A  = ADDR_W'(RATE_ADDR);
  localparam logic [ADDR_W-1:0] KICK_A  = ADDR_W'(KICK_ADDR);
  localparam int                WCNT_W  = $clog2(WIN_TICKS);
  localparam logic [WCNT_W-1:0] WLAST   = WCNT_W'(WIN_TICKS - 1);

  logic [REG_W-1:0]  rateReg;
  logic [WCNT_W-1:0] winCnt;
  logic              loadDly;
  logic              rateWr;
  logic              kickWr;

  assign rateWr = regWr && (regAddr == RATE_A);
  assign kickWr = regWr && (regAddr == KICK_A) && regWrData[KICK_BIT];

  // Shared rate register: all bits stored
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateReg <= '0;
    end else if (rateWr) begin
      rateReg <= regWrData;
    end
  end

  assign newCode = rateReg[FIELD_LSB +: CODE_W];

  // Window position in ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (tick) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    strb.tick   = tick;
    strb.winEnd = tick && (winCnt == WLAST);
    strb.load   = strb.winEnd && kickBusy;
  end

  // Busy flag: set by software, cleared the cycle after the apply
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadDly  <= 1'b0;
      kickBusy <= 1'b0;
    end else begin
      loadDly <= strb.load;
      if (loadDly) begin
        kickBusy <= 1'b0;
      end else if (kickWr) begin
        kickBusy <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == RATE_A) begin
      regRdData = rateReg;
    end else if (regAddr == KICK_A) begin
      regRdData[KICK_BIT] = kickBusy;
    end
  end

endmodule

// File: rtl/nof32_gate_dp.sv
module nof32_gate_dp
  import nof32_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  gateStrb_t         strb,
  input  logic [CODE_W-1:0] newCode,
  output logic              clkEn,
  output logic [CODE_W-1:0] curCode
);

  // acc holds the fractional phase (0..31); sum tops out at 63
  logic [CODE_W-1:0] acc;
  logic [CODE_W:0]   mult;
  logic [CODE_W:0]   sum;

  assign mult = (CODE_W+1)'(WIN_TICKS) - {1'b0, curCode};
  assign sum  = {1'b0, acc} + mult;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      clkEn   <= 1'b0;
      curCode <= '0;
    end else begin
      clkEn <= strb.tick && sum[CODE_W];
      if (strb.tick) begin
        acc <= sum[CODE_W-1:0];
      end
      if (strb.load) begin
        curCode <= newCode;
      end
    end
  end

endmodule

// File: rtl/nof32_gate.sv
module nof32_gate
  import nof32_gate_pkg::*;
#(
  parameter int FIXED_DIV = 1,
  parameter int ADDR_W    = 4,
  parameter int RATE_ADDR = 0,
  parameter int KICK_ADDR = 1,
  parameter int FIELD_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              clkEn
);

  logic              tick;
  gateStrb_t         strb;
  logic [CODE_W-1:0] newCode;
  logic [CODE_W-1:0] activeCode;
  logic              kickBusy;

  nof32_prediv #(.FIXED_DIV(FIXED_DIV)) u_prediv (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  nof32_gate_ctrl #(
    .ADDR_W    (ADDR_W),
    .RATE_ADDR (RATE_ADDR),
    .KICK_ADDR (KICK_ADDR),
    .FIELD_LSB (FIELD_LSB)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .tick      (tick),
    .strb      (strb),
    .newCode   (newCode),
    .kickBusy  (kickBusy)
  );

  nof32_gate_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .newCode (newCode),
    .clkEn   (clkEn),
    .curCode (activeCode)
  );

endmodule

// File: rtl/nof32_gate_chk.sv
module nof32_gate_chk
  import nof32_gate_pkg::*;
#(
  parameter int FIXED_DIV = 1,
  parameter int ADDR_W    = 4,
  parameter int KICK_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input gateStrb_t         strb,
  input logic [CODE_W-1:0] activeCode,
  input logic              kickBusy,
  input logic              clkEn
);

  logic [6:0] pulseCnt;
  logic [6:0] multLatch;
  logic       endSeen;

  // Window pulse tally compared with the ratio that ran the window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt  <= '0;
      multLatch <= 7'd32;
      endSeen   <= 1'b0;
    end else begin
      endSeen <= strb.winEnd;
      if (strb.winEnd) begin
        multLatch <= 7'd32 - {2'b0, activeCode};
      end
      if (endSeen) begin
        pulseCnt <= '0;
      end else begin
        pulseCnt <= pulseCnt + {6'b0, clkEn};
      end
    end
  end

  a_r1_window_count: assert property (@(posedge clk) disable iff (!rstN)
    endSeen |-> (pulseCnt + {6'b0, clkEn}) == multLatch);

  a_r1_pulse_from_tick: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> $past(strb.tick));

  a_r4_prediv_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (FIXED_DIV > 1) && clkEn |=> !clkEn);

  a_r7_code_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeCode) |-> $past(strb.winEnd && kickBusy));

  a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kickBusy) |-> $past(strb.winEnd, 2));

  a_r6_busy_set: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kickBusy) |-> $past(regWr && regAddr == ADDR_W'(KICK_ADDR) && regWrData[31]));

endmodule

bind nof32_gate nof32_gate_chk #(
  .FIXED_DIV (FIXED_DIV),
  .ADDR_W    (ADDR_W),
  .KICK_ADDR (KICK_ADDR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .strb       (strb),
  .activeCode (activeCode),
  .kickBusy   (kickBusy),
  .clkEn      (clkEn)
);

// File: tb/nof32_gate_bench.sv
`timescale 1ns/1ps
module nof32_gate_bench;

  localparam int DIV     = 3;
  localparam int LSB     = 8;
  localparam int WIN_CYC = 32 * DIV;
  localparam logic [3:0] RATE_A = 4'd0;
  localparam logic [3:0] KICK_A = 4'd1;

  typedef struct {
    int    exp;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        clkEn;

  nof32_gate #(.FIXED_DIV(DIV), .FIELD_LSB(LSB)) u_nof32_gate (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .clkEn     (clkEn)
  );

  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  int edgeCnt = 0;
  int winPulses = 0;
  int lastPulse = -1;
  int firstPulse = -1;
  int gapMin = 1 << 20;
  int gapMax = 0;
  int curMult = 32;
  expItem_t expQ[$];
  event winEv;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  // Monitor: counts pulses, tracks spacing, closes windows
  always @(negedge clk) begin
    if (rstN && edgeCnt > 0) begin
      if (clkEn) begin
        winPulses++;
        if (firstPulse < 0) firstPulse = edgeCnt;
        if (lastPulse >= 0) begin
          if (edgeCnt - lastPulse < gapMin) gapMin = edgeCnt - lastPulse;
          if (edgeCnt - lastPulse > gapMax) gapMax = edgeCnt - lastPulse;
        end
        lastPulse = edgeCnt;
      end
      if (edgeCnt % WIN_CYC == 0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 no expectation queued", winPulses, -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(winPulses == it.exp, it.tag, winPulses, it.exp);
        end
        winPulses = 0;
        ->winEv;
      end
    end
  end

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic runWin(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back('{curMult, tag});
      @winEv;
    end
  endtask

  function automatic logic [31:0] packRate(input int code, input logic [31:0] other);
    return (other & ~(32'h1F << LSB)) | (32'(code) << LSB);
  endfunction

  // Commit a ratio; optional rewrite of the field while pending
  task automatic applyRatio(input int code, input logic [31:0] other,
                            input bit doWrite, input int rewrite);
    logic [31:0] rd;
    int effCode;
    effCode = code;
    if (doWrite) begin
      writeReg(RATE_A, packRate(code, other));
      readReg(RATE_A, rd);
      check(rd == packRate(code, other), "R9 rate readback", rd, packRate(code, other));
    end
    writeReg(KICK_A, 32'hFFFF_FFFF);
    readReg(KICK_A, rd);
    check(rd == 32'h8000_0000, "R6 busy reads back on bit 31 only", rd, 32'h8000_0000);
    writeReg(KICK_A, 32'h0000_0000);
    readReg(KICK_A, rd);
    check(rd == 32'h8000_0000, "R6 zero write leaves busy set", rd, 32'h8000_0000);
    if (rewrite >= 0) begin
      writeReg(RATE_A, packRate(rewrite, other));
      effCode = rewrite;
    end
    expQ.push_back('{curMult, "R7 old ratio holds in commit window"});
    @winEv;
    readReg(KICK_A, rd);
    check(rd[31] == 1'b1, "R8 busy still set at boundary", rd[31], 1);
    @(negedge clk);
    readReg(KICK_A, rd);
    check(rd[31] == 1'b0, "R8 busy cleared one cycle after boundary", rd[31], 0);
    curMult = 32 - effCode;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    readReg(RATE_A, rd);
    check(rd == 0, "R10 rate register reset", rd, 0);
    readReg(KICK_A, rd);
    check(rd == 0, "R10 busy reset", rd, 0);
    check(clkEn == 1'b0, "R10 clkEn reset", clkEn, 0);
    rstN = 1'b1;

    // Full rate: code 0
    runWin(1, "R2 code 0 full rate");
    check(firstPulse == DIV, "R4 first pulse after reset", firstPulse, DIV);
    check(gapMin == DIV && gapMax == DIV, "R4 tick spacing at full rate", gapMax, DIV);

    // One of 32
    applyRatio(31, 32'h0, 1'b1, -1);
    runWin(2, "R2 code 31 one pulse");

    // Five of 32 with junk around the field
    applyRatio(27, 32'hA5A5_A5A5, 1'b1, -1);
    runWin(1, "R1 R9 five per window");
    gapMin = 1 << 20; gapMax = 0;
    runWin(2, "R1 five per window");
    check(gapMin >= 6 * DIV, "R3 min spacing mult 5", gapMin, 6 * DIV);
    check(gapMax <= 7 * DIV, "R3 max spacing mult 5", gapMax, 7 * DIV);

    // Field write without commit
    writeReg(RATE_A, packRate(16, 32'h0));
    readReg(RATE_A, rd);
    check(rd == packRate(16, 32'h0), "R9 rate readback", rd, packRate(16, 32'h0));
    runWin(2, "R5 uncommitted field ignored");

    // Commit alone picks up the stored field
    applyRatio(16, 32'h0, 1'b0, -1);
    runWin(1, "R1 R7 sixteen per window");

    // Rewrite while pending: latest field wins
    applyRatio(3, 32'h0, 1'b1, 20);
    runWin(1, "R7 rewritten field applied");

    // Back to full rate
    applyRatio(0, 32'hFFFF_FFFF, 1'b1, -1);
    runWin(1, "R2 R9 back to full rate");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule